// File: doc/BRIEF.md
# Prioritised Write Queue with Read Forwarding

This block sits between a write-through cache and a single memory bus. Processor stores are pushed into a small first-in first-out queue and the processor carries on at once. The queue then drains to memory in the background whenever the bus has nothing more urgent to do. Processor loads that missed in the cache are the urgent traffic. The processor waits for each load, so a load miss is put on the bus ahead of any store that is still queued.

Because loads overtake stores, memory can hold an old value for an address that has a newer value in the queue. Every load therefore searches all queued entries first. If one or more entries carry the same address, the data of the most recently queued one is returned without using the bus. Each bus transaction is a request, then a grant, then a data cycle. Only one transaction is outstanding at a time.

Top module: `wbuf_rdfwd`

## Requirements
- R1: During reset and right after it, `cpu_wr_ready` is 1, `bus_req` is 0 and `cpu_rd_done` is 0, and the queue holds no entries.
- R2: A store offered while fewer than DEPTH entries are queued is accepted at the next clock edge with no stall. With DEPTH entries queued, `cpu_wr_ready` is 0 and the offered store waits, and is accepted exactly once, after an entry drains. The occupancy never exceeds DEPTH.
- R3: Queued stores reach the bus in the order they were accepted. Each carries the address and data it was accepted with and `bus_we` = 1. A store request is only raised while the queue holds at least one entry.
- R4: `bus_req` stays high, with `bus_addr`, `bus_we` and `bus_wdata` unchanged, until a cycle in which `bus_gnt` is 1. It is low in the cycle after that. The transaction ends in the first later cycle with `bus_dvalid` = 1 (the data cycle).
- R5: When the bus controller is free and a load miss is waiting, it requests the load (`bus_we` = 0) before any store still in the queue. A store whose request is already raised is finished first.
- R6: A load whose address matches a queued entry completes with `cpu_rd_done` = 1 in the cycle after it is presented, returns the queued data, and causes no bus transaction. This holds even while a store transaction is in progress.
- R7: When several queued entries match the load address, the data of the youngest matching entry is returned.
- R8: A load with no matching entry is issued on the bus. The `bus_rdata` value from its data cycle appears on `cpu_rd_data` with `cpu_rd_done` = 1 in the following cycle. With a grant in the first request cycle and the data cycle right after it, the load completes three cycles after it is presented. `cpu_rd_done` is a one-cycle pulse.
- R9: With no processor activity, all queued stores drain to memory and `cpu_wr_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr_valid | input | 1 | Store offered by the processor |
| cpu_wr_addr | input | AW | Store address |
| cpu_wr_data | input | DW | Store data |
| cpu_wr_ready | output | 1 | Queue can take a store this cycle |
| cpu_rd_valid | input | 1 | Load miss presented; held until `cpu_rd_done` |
| cpu_rd_addr | input | AW | Load address |
| cpu_rd_done | output | 1 | Load result valid (one-cycle pulse) |
| cpu_rd_data | output | DW | Load result |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for a store transaction, 0 for a load |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Store data |
| bus_gnt | input | 1 | Grant for the pending request |
| bus_dvalid | input | 1 | Data cycle of the granted transaction |
| bus_rdata | input | DW | Load data, valid with `bus_dvalid` |

## Verification
A mixed sequence of stores and loads runs with the bus always granting. In it, every load result must equal the newest value stored to that address, so a stale memory value or an older queue entry is caught whether or not the load was forwarded. Directed patterns then hold grants back to freeze the queue. Repeated stores to one address separate youngest-match selection from oldest-match selection, and a fifth store shows the stall and its single acceptance. A load miss placed behind three stores shows whether it overtakes the two that are not yet requested. Latency counts separate a forwarded load (one cycle, no bus read) from a bus load (three cycles).

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   // Bus side sequencer: one transaction in flight at most.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // free to choose the next transaction
      ST_REQ  = 2'd1,   // request raised, waiting for the grant
      ST_WAIT = 2'd2    // granted, waiting for the data cycle
   } bus_st_e;

   // Kind of transaction carried on the bus (value drives bus_we).
   typedef enum logic {
      TXN_LOAD  = 1'b0,
      TXN_STORE = 1'b1
   } txn_e;

   function automatic logic is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [AW-1:0]              push_addr,
   input  logic [DW-1:0]              push_data,
   input  logic                       pop,
   output logic                       full,
   output logic                       empty,
   output logic [CW-1:0]              count,
   output logic [PW-1:0]              head_ptr,
   output logic [AW-1:0]              head_addr,
   output logic [DW-1:0]              head_data,
   output logic [DEPTH-1:0][AW-1:0]   slot_addr,
   output logic [DEPTH-1:0][DW-1:0]   slot_data,
   output logic [DEPTH-1:0]           slot_live
);

   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;
   logic [CW-1:0] cnt;

   // Pointers and occupancy. Pointers wrap naturally since DEPTH is 2**PW.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_ptr + PW'(1);
         end
         if (pop) begin
            rd_ptr <= rd_ptr + PW'(1);
         end
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   // One storage slot per queue position.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic sel_wr;
      logic sel_rd;
      assign sel_wr = push && (wr_ptr == PW'(gi));
      assign sel_rd = pop  && (rd_ptr == PW'(gi));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_live[gi] <= 1'b0;
         end else if (sel_wr) begin
            slot_live[gi] <= 1'b1;
         end else if (sel_rd) begin
            slot_live[gi] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (sel_wr) begin
            slot_addr[gi] <= push_addr;
            slot_data[gi] <= push_data;
         end
      end
   end

   assign full      = (cnt == CW'(DEPTH));
   assign empty     = (cnt == '0);
   assign count     = cnt;
   assign head_ptr  = rd_ptr;
   assign head_addr = slot_addr[rd_ptr];
   assign head_data = slot_data[rd_ptr];

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic [AW-1:0]              probe_addr,
   input  logic [PW-1:0]              head_ptr,
   input  logic [DEPTH-1:0][AW-1:0]   slot_addr,
   input  logic [DEPTH-1:0][DW-1:0]   slot_data,
   input  logic [DEPTH-1:0]           slot_live,
   output logic                       hit,
   output logic [DW-1:0]              hit_data
);

   logic [DEPTH-1:0] eq;
   logic [PW-1:0]    idx;

   // One address comparator per occupied slot.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign eq[gi] = slot_live[gi] && (slot_addr[gi] == probe_addr);
   end

   // Walk from oldest (head) to youngest; a later match overrides, so the
   // youngest matching entry supplies the data.
   always_comb begin
      hit      = 1'b0;
      hit_data = '0;
      idx      = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head_ptr + PW'(k);
         if (eq[idx]) begin
            hit      = 1'b1;
            hit_data = slot_data[idx];
         end
      end
   end

endmodule

// File: rtl/wbuf_busctl.sv
module wbuf_busctl
   import wbuf_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_rd_valid,
   input  logic [AW-1:0] cpu_rd_addr,
   input  logic          fwd_hit,
   input  logic [DW-1:0] fwd_data,
   input  logic          q_empty,
   input  logic [AW-1:0] head_addr,
   input  logic [DW-1:0] head_data,
   output logic          pop,
   output logic          rd_busy,
   output logic          rd_done,
   output logic [DW-1:0] rd_data,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_gnt,
   input  logic          bus_dvalid,
   input  logic [DW-1:0] bus_rdata
);

   bus_st_e       st;
   bus_st_e       st_nx;
   txn_e          cur_kind;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] cur_wdata;
   logic          done_q;
   logic [DW-1:0] data_q;

   logic rd_pend;
   logic rd_onbus;
   logic fwd_take;
   logic start_rd;
   logic start_wr;
   logic xfer_end;

   // A load is pending until its result pulse has been given.
   assign rd_pend  = cpu_rd_valid && !done_q;
   assign rd_onbus = (st != ST_IDLE) && (cur_kind == TXN_LOAD);
   // Forwarding needs no bus, so it may complete during a store transaction.
   assign fwd_take = rd_pend && fwd_hit && !rd_onbus;
   // Load misses win the choice over queued stores.
   assign start_rd = (st == ST_IDLE) && rd_pend && !fwd_hit;
   assign start_wr = (st == ST_IDLE) && !start_rd && !q_empty;
   assign xfer_end = (st == ST_WAIT) && bus_dvalid;
   assign pop      = xfer_end && (cur_kind == TXN_STORE);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (start_rd || start_wr) st_nx = ST_REQ;
         ST_REQ:  if (bus_gnt)              st_nx = ST_WAIT;
         ST_WAIT: if (bus_dvalid)           st_nx = ST_IDLE;
         default:                           st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_kind  <= TXN_LOAD;
         cur_addr  <= '0;
         cur_wdata <= '0;
      end else begin
         st <= st_nx;
         if (start_rd) begin
            cur_kind  <= TXN_LOAD;
            cur_addr  <= cpu_rd_addr;
            cur_wdata <= '0;
         end else if (start_wr) begin
            cur_kind  <= TXN_STORE;
            cur_addr  <= head_addr;
            cur_wdata <= head_data;
         end
      end
   end

   // Load result register: one pulse per completed load.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         data_q <= '0;
      end else begin
         done_q <= fwd_take || (xfer_end && (cur_kind == TXN_LOAD));
         if (fwd_take) begin
            data_q <= fwd_data;
         end else if (xfer_end && (cur_kind == TXN_LOAD)) begin
            data_q <= bus_rdata;
         end
      end
   end

   assign rd_busy   = rd_onbus;
   assign rd_done   = done_q;
   assign rd_data   = data_q;
   assign bus_req   = (st == ST_REQ);
   assign bus_we    = (cur_kind == TXN_STORE);
   assign bus_addr  = cur_addr;
   assign bus_wdata = cur_wdata;

endmodule

// File: rtl/wbuf_rdfwd.sv
module wbuf_rdfwd
   import wbuf_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_wr_valid,
   input  logic [AW-1:0] cpu_wr_addr,
   input  logic [DW-1:0] cpu_wr_data,
   output logic          cpu_wr_ready,
   input  logic          cpu_rd_valid,
   input  logic [AW-1:0] cpu_rd_addr,
   output logic          cpu_rd_done,
   output logic [DW-1:0] cpu_rd_data,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic          bus_gnt,
   input  logic          bus_dvalid,
   input  logic [DW-1:0] bus_rdata
);

   // Elaboration-time parameter checks.
   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("wbuf_rdfwd: DEPTH must be a power of two and at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("wbuf_rdfwd: AW and DW must be at least 1");
   end

   logic                     q_full;
   logic                     q_empty;
   logic [CW-1:0]            q_count;
   logic [PW-1:0]            q_head_ptr;
   logic [AW-1:0]            q_head_addr;
   logic [DW-1:0]            q_head_data;
   logic [DEPTH-1:0][AW-1:0] q_slot_addr;
   logic [DEPTH-1:0][DW-1:0] q_slot_data;
   logic [DEPTH-1:0]         q_slot_live;
   logic                     q_push;
   logic                     q_pop;
   logic                     fwd_hit;
   logic [DW-1:0]            fwd_data;
   logic                     rd_busy;

   assign cpu_wr_ready = !q_full;
   assign q_push       = cpu_wr_valid && !q_full;

   wbuf_fifo #(
      .AW    (AW),
      .DW    (DW),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_addr (cpu_wr_addr),
      .push_data (cpu_wr_data),
      .pop       (q_pop),
      .full      (q_full),
      .empty     (q_empty),
      .count     (q_count),
      .head_ptr  (q_head_ptr),
      .head_addr (q_head_addr),
      .head_data (q_head_data),
      .slot_addr (q_slot_addr),
      .slot_data (q_slot_data),
      .slot_live (q_slot_live)
   );

   wbuf_match #(
      .AW    (AW),
      .DW    (DW),
      .DEPTH (DEPTH)
   ) u_match (
      .probe_addr (cpu_rd_addr),
      .head_ptr   (q_head_ptr),
      .slot_addr  (q_slot_addr),
      .slot_data  (q_slot_data),
      .slot_live  (q_slot_live),
      .hit        (fwd_hit),
      .hit_data   (fwd_data)
   );

   wbuf_busctl #(
      .AW (AW),
      .DW (DW)
   ) u_busctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_rd_valid (cpu_rd_valid),
      .cpu_rd_addr  (cpu_rd_addr),
      .fwd_hit      (fwd_hit),
      .fwd_data     (fwd_data),
      .q_empty      (q_empty),
      .head_addr    (q_head_addr),
      .head_data    (q_head_data),
      .pop          (q_pop),
      .rd_busy      (rd_busy),
      .rd_done      (cpu_rd_done),
      .rd_data      (cpu_rd_data),
      .bus_req      (bus_req),
      .bus_we       (bus_we),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_gnt      (bus_gnt),
      .bus_dvalid   (bus_dvalid),
      .bus_rdata    (bus_rdata)
   );

endmodule

// File: rtl/wbuf_rdfwd_chk.sv
module wbuf_rdfwd_chk #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_rd_valid,
   input logic          cpu_rd_done,
   input logic          bus_req,
   input logic          bus_we,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          bus_gnt,
   input logic [CW-1:0] occ,
   input logic          fwd_hit,
   input logic          rd_busy
);

   // R2: queue occupancy stays within its depth.
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   // R3: a store request is always backed by a queued entry.
   assert_store_backed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> (occ != '0));

   // R4: an ungranted request is held with unchanged attributes.
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata)));

   // R4: the request drops after its grant.
   assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt) |=> !bus_req);

   // R5: a request raised while a load miss was waiting is the load.
   assert_load_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && $past(cpu_rd_valid && !cpu_rd_done && !fwd_hit)) |-> !bus_we);

   // R6: a matching load not already on the bus completes next cycle.
   assert_fwd_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_valid && !cpu_rd_done && fwd_hit && !rd_busy) |=> cpu_rd_done);

   // R8: the load result is a one-cycle pulse.
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd_done |=> !cpu_rd_done);

endmodule

bind wbuf_rdfwd wbuf_rdfwd_chk #(
   .AW    (AW),
   .DW    (DW),
   .DEPTH (DEPTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_rd_valid (cpu_rd_valid),
   .cpu_rd_done  (cpu_rd_done),
   .bus_req      (bus_req),
   .bus_we       (bus_we),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .bus_gnt      (bus_gnt),
   .occ          (q_count),
   .fwd_hit      (fwd_hit),
   .rd_busy      (rd_busy)
);

// File: tb/sim_wbuf_rdfwd.sv
module sim_wbuf_rdfwd;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int DEPTH = 4;
   localparam int NVEC  = 12;
   localparam int LOGSZ = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_wr_valid = 1'b0;
   logic [AW-1:0] cpu_wr_addr = '0;
   logic [DW-1:0] cpu_wr_data = '0;
   logic          cpu_wr_ready;
   logic          cpu_rd_valid = 1'b0;
   logic [AW-1:0] cpu_rd_addr = '0;
   logic          cpu_rd_done;
   logic [DW-1:0] cpu_rd_data;
   logic          bus_req;
   logic          bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_gnt = 1'b0;
   logic          bus_dvalid = 1'b0;
   logic [DW-1:0] bus_rdata = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wbuf_rdfwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
      .cpu_wr_ready(cpu_wr_ready),
      .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr),
      .cpu_rd_done(cpu_rd_done), .cpu_rd_data(cpu_rd_data),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_dvalid(bus_dvalid), .bus_rdata(bus_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- bus responder and memory model ----------------
   bit            hold_gnt = 1'b0;
   int            phase = 0;
   logic [AW-1:0] t_addr;
   logic [DW-1:0] t_data;
   logic          t_we;
   logic [DW-1:0] mem [logic [AW-1:0]];
   logic [AW-1:0] log_a  [LOGSZ];
   logic [DW-1:0] log_d  [LOGSZ];
   logic          log_we [LOGSZ];
   int            log_n = 0;
   int            rd_grants = 0;

   function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
      if (mem.exists(a)) return mem[a];
      return {16'hD000, a};
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         case (phase)
            0: begin
               bus_dvalid = 1'b0;
               if (rst_n && bus_req && !hold_gnt) begin
                  bus_gnt = 1'b1;
                  t_addr  = bus_addr;
                  t_we    = bus_we;
                  t_data  = bus_wdata;
                  if (log_n < LOGSZ) begin
                     log_a[log_n]  = bus_addr;
                     log_d[log_n]  = bus_wdata;
                     log_we[log_n] = bus_we;
                  end
                  log_n++;
                  if (!bus_we) rd_grants++;
                  phase = 1;
               end
            end
            1: begin
               bus_gnt    = 1'b0;
               bus_dvalid = 1'b1;
               if (t_we) mem[t_addr] = t_data;
               else bus_rdata = mem_rd(t_addr);
               phase = 2;
            end
            default: begin
               bus_dvalid = 1'b0;
               phase = 0;
            end
         endcase
      end
   end

   // ---------------- processor-side tasks (start and end at a negedge) ----------------
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stall);
      cpu_wr_addr  = a;
      cpu_wr_data  = d;
      cpu_wr_valid = 1'b1;
      stall = 0;
      while (!cpu_wr_ready) begin
         @(negedge clk);
         stall++;
      end
      @(negedge clk);
      cpu_wr_valid = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
      cpu_rd_addr  = a;
      cpu_rd_valid = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!cpu_rd_done && lat < 500);
      d = cpu_rd_data;
      cpu_rd_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (40) @(negedge clk);
   endtask

   // ---------------- stimulus / expected-result table ----------------
   typedef struct packed {
      logic          wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [DW-1:0] e;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 16'h0010, 32'h1111_0001, 32'h0},
      '{1'b1, 16'h0020, 32'h2222_0002, 32'h0},
      '{1'b0, 16'h0010, 32'h0,         32'h1111_0001},
      '{1'b1, 16'h0010, 32'h1111_0003, 32'h0},
      '{1'b0, 16'h0010, 32'h0,         32'h1111_0003},
      '{1'b0, 16'h0030, 32'h0,         32'hD000_0030},
      '{1'b1, 16'h0030, 32'h3333_0004, 32'h0},
      '{1'b1, 16'h0030, 32'h3333_0005, 32'h0},
      '{1'b0, 16'h0030, 32'h0,         32'h3333_0005},
      '{1'b0, 16'h0020, 32'h0,         32'h2222_0002},
      '{1'b1, 16'h0040, 32'h4444_0006, 32'h0},
      '{1'b0, 16'h0040, 32'h0,         32'h4444_0006}
   };

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [DW-1:0] rd;
      int lat;
      int st;
      int s_log;
      int s_rg;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(cpu_wr_ready == 1'b1, "R1 ready in reset", DW'(cpu_wr_ready), 1);
      chk(bus_req == 1'b0, "R1 no request in reset", DW'(bus_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_rd_done == 1'b0, "R1 no load done after reset", DW'(cpu_rd_done), 0);
      chk(bus_req == 1'b0 && cpu_wr_ready, "R1 idle after reset",
          DW'({bus_req, cpu_wr_ready}), 1);

      // Table walk with a bus that always grants: loads see newest value (R6/R8).
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i].wr) begin
            do_write(VEC[i].a, VEC[i].d, st);
         end else begin
            do_read(VEC[i].a, rd, lat);
            chk(rd == VEC[i].e, $sformatf("R6/R8 table vector %0d", i), rd, VEC[i].e);
         end
      end

      // R9: everything drains with no activity
      settle();
      chk(cpu_wr_ready == 1'b1, "R9 ready after drain", DW'(cpu_wr_ready), 1);
      chk(mem_rd(16'h0010) == 32'h1111_0003, "R9 memory 0x10", mem_rd(16'h0010), 32'h1111_0003);
      chk(mem_rd(16'h0030) == 32'h3333_0005, "R9 memory 0x30", mem_rd(16'h0030), 32'h3333_0005);
      chk(mem_rd(16'h0040) == 32'h4444_0006, "R9 memory 0x40", mem_rd(16'h0040), 32'h4444_0006);

      // R6: forward with bus active, store then immediate load
      do_write(16'h0600, 32'h6666_0600, st);
      s_rg = rd_grants;
      do_read(16'h0600, rd, lat);
      chk(rd == 32'h6666_0600, "R6 forwarded data", rd, 32'h6666_0600);
      chk(lat == 1, "R6 forward latency", DW'(lat), 1);
      chk(rd_grants == s_rg, "R6 no bus load", DW'(rd_grants - s_rg), 0);
      settle();

      // R7 + R3: youngest of several matches, grants frozen
      hold_gnt = 1'b1;
      s_log = log_n;
      s_rg  = rd_grants;
      do_write(16'h0050, 32'hAAAA_0001, st);
      do_write(16'h0060, 32'hBBBB_0002, st);
      do_write(16'h0050, 32'hCCCC_0003, st);
      do_read(16'h0050, rd, lat);
      chk(rd == 32'hCCCC_0003, "R7 youngest match", rd, 32'hCCCC_0003);
      chk(lat == 1, "R6 forward latency while store request pending", DW'(lat), 1);
      do_read(16'h0060, rd, lat);
      chk(rd == 32'hBBBB_0002, "R6 single match", rd, 32'hBBBB_0002);
      chk(rd_grants == s_rg, "R6 no bus load while frozen", DW'(rd_grants - s_rg), 0);
      hold_gnt = 1'b0;
      settle();
      chk(mem_rd(16'h0050) == 32'hCCCC_0003, "R3 last store wins in memory",
          mem_rd(16'h0050), 32'hCCCC_0003);
      chk(log_a[s_log] == 16'h0050 && log_d[s_log] == 32'hAAAA_0001, "R3 order entry 0",
          log_d[s_log], 32'hAAAA_0001);
      chk(log_a[s_log+1] == 16'h0060 && log_d[s_log+1] == 32'hBBBB_0002, "R3 order entry 1",
          log_d[s_log+1], 32'hBBBB_0002);
      chk(log_a[s_log+2] == 16'h0050 && log_d[s_log+2] == 32'hCCCC_0003, "R3 order entry 2",
          log_d[s_log+2], 32'hCCCC_0003);

      // R2: full queue stalls; stalled store accepted once
      hold_gnt = 1'b1;
      s_log = log_n;
      for (int k = 0; k < DEPTH; k++) begin
         do_write(AW'(16'h0100 + k), DW'(32'h5000_0000 + k), st);
         chk(st == 0, $sformatf("R2 no stall for store %0d", k), DW'(st), 0);
      end
      chk(cpu_wr_ready == 1'b0, "R2 ready low when full", DW'(cpu_wr_ready), 0);
      fork
         do_write(16'h0200, 32'h0000_BEEF, st);
         begin
            repeat (6) @(negedge clk);
            hold_gnt = 1'b0;
         end
      join
      chk(st > 0, "R2 store stalled while full", DW'(st), 1);
      settle();
      chk(log_n - s_log == DEPTH + 1, "R2 stalled store accepted once",
          DW'(log_n - s_log), DW'(DEPTH + 1));
      for (int k = 0; k < DEPTH; k++) begin
         chk(log_we[s_log+k] && log_a[s_log+k] == AW'(16'h0100 + k),
             $sformatf("R3 full-queue order %0d", k), DW'(log_a[s_log+k]), DW'(16'h0100 + k));
      end
      chk(log_a[s_log+DEPTH] == 16'h0200 && log_d[s_log+DEPTH] == 32'h0000_BEEF,
          "R3 stalled store drains last", log_d[s_log+DEPTH], 32'h0000_BEEF);

      // R5: load miss overtakes stores not yet requested
      hold_gnt = 1'b1;
      s_log = log_n;
      do_write(16'h0300, 32'h7000_0001, st);
      do_write(16'h0304, 32'h7000_0002, st);
      do_write(16'h0308, 32'h7000_0003, st);
      fork
         do_read(16'h0400, rd, lat);
         begin
            repeat (4) @(negedge clk);
            hold_gnt = 1'b0;
         end
      join
      chk(rd == 32'hD000_0400, "R8 load miss data", rd, 32'hD000_0400);
      settle();
      chk(log_we[s_log] == 1'b1 && log_a[s_log] == 16'h0300, "R5 committed store first",
          DW'(log_a[s_log]), 32'h0300);
      chk(log_we[s_log+1] == 1'b0 && log_a[s_log+1] == 16'h0400, "R5 load overtakes",
          DW'({log_we[s_log+1], log_a[s_log+1]}), 32'h0400);
      chk(log_we[s_log+2] && log_we[s_log+3] && log_a[s_log+3] == 16'h0308,
          "R5 remaining stores after load", DW'(log_a[s_log+3]), 32'h0308);

      // R8: bus load latency with immediate grant
      s_rg = rd_grants;
      do_read(16'h0500, rd, lat);
      chk(rd == 32'hD000_0500, "R8 bus load data", rd, 32'hD000_0500);
      chk(lat == 3, "R8 bus load latency", DW'(lat), 3);
      chk(rd_grants == s_rg + 1, "R8 one bus load", DW'(rd_grants - s_rg), 1);
      @(negedge clk);
      chk(cpu_rd_done == 1'b0, "R8 done is a pulse", DW'(cpu_rd_done), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule